// File: doc/BRIEF.md
# Card Bus Power-Up Initialization Sequencer

This host-side block takes a removable memory card from its power-up state to the point where it can be identified, using a one-bit command line. After reset it holds the command line high while the card clock runs. This warm-up lasts until three conditions all hold: a minimum wall-clock time counted in system clocks, a minimum number of card clocks, and a supply-ready input. The block then sends the operating-condition command (index 1) again and again, carrying the host's voltage-range word as its argument, and reads the readiness flag in each 48-bit reply.

When a reply reports the card ready, the block waits out the turnaround gap, sends the identify command (index 2), and raises `done`. A reply that reports busy, or no reply at all within a fixed number of card clocks, leads to another index-1 command after the gap. An overall limit, counted in system clocks from the first index-1 command, ends polling. At that limit the block raises `timeout` and leaves the line idle. The caller supplies a one-cycle card-clock enable. Each command bit is driven, and each reply bit is sampled, on a system-clock edge where that enable is high.

Top module: `card_wake_seq`

## Requirements
- R1: From reset until the warm-up ends, `cmd_out` stays 1 and at least `INIT_CLKS` card-clock enables pass with the line high before the first command's start bit.
- R2: The warm-up ends at the latest of three events: `MS_TICKS` system clocks since reset, `INIT_CLKS` card clocks, and `supply_ok` high. The first start bit appears within one card clock (plus two system clocks) after that.
- R3: Every command is 48 bits sent MSB first. Bit 47 is 0, bit 46 is 1, bits 45:40 hold the index, bits 39:8 hold the argument, bits 7:1 hold the CRC7 (x^7+x^3+1, zero seed) of bits 47:8, and bit 0 is 1.
- R4: The first command is index 1 with argument equal to `op_range`.
- R5: A reply is 48 bits that begin with a 0 start bit on `cmd_in`. Its bits 39:8 are latched onto `ocr`. When payload bit 31 is 0 (busy), the next command is again index 1 with argument `op_range`.
- R6: When payload bit 31 is 1 (ready), the next command is index 2 with argument 0. `done` rises after its end bit, `ocr` keeps the ready payload, and no further command follows.
- R7: If the card is still not ready `SEC_TICKS` system clocks after the first index-1 start, `timeout` rises and `cmd_out` stays 1 from then on. `done` and `timeout` are never both high.
- R8: At least `GAP_CLKS` card clocks pass with the line high between a reply's end bit and the next start bit.
- R9: If no start bit is sampled within `RSP_WAIT` card clocks after a command, the attempt counts as busy and index 1 is sent again.
- R10: During reset `cmd_out` is 1, and `done`, `timeout` and `ocr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cclk_en | input | 1 | One-cycle enable marking each card clock |
| supply_ok | input | 1 | Supply has reached the operating level |
| op_range | input | 32 | Voltage-range argument for the index-1 command |
| cmd_in | input | 1 | Command line as driven by the card |
| cmd_out | output | 1 | Command line as driven by the host (idle 1) |
| done | output | 1 | Card ready and identify command sent |
| timeout | output | 1 | Card stayed busy past the overall limit |
| ocr | output | 32 | Payload of the most recent reply |

## Verification
The hardest condition to reach from the ports is the overall time limit expiring while polling is still under way. It needs thousands of system clocks of well-formed busy replies, or of silence, with the limit landing at an arbitrary point inside a command, a reply wait or a gap. The bench builds the block with a small limit and runs a card model that either answers busy for ever or never answers. The expiry point drifts through the polling cycle, and the bench checks that the line falls silent with no truncated frame being taken as a command. Each warm-up condition is made the dominant one in turn by changing the card-clock divider and the supply delay.

// File: rtl/card_wake_pkg.sv
package card_wake_pkg;

   localparam int FRAME_W = 48;
   localparam int BODY_W  = 40;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_OP_TX,
      ST_OP_WAIT,
      ST_OP_GAP,
      ST_ID_GAP,
      ST_ID_TX,
      ST_DONE,
      ST_TOUT
   } seq_st_t;

   // serial CRC7 over the frame body, generator x^7 + x^3 + 1
   function automatic logic [6:0] crc7_of(input logic [BODY_W-1:0] body);
      logic [6:0] c;
      logic       fb;
      c = '0;
      for (int i = BODY_W - 1; i >= 0; i--) begin
         fb = body[i] ^ c[6];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

endpackage

// File: rtl/cws_limit_timer.sv
module cws_limit_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic hit
);
   generate
      if (LIMIT == 0) begin : g_none
         assign hit = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] TOP = CW'(LIMIT);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt <= '0;
            else if (clear)             cnt <= '0;
            else if (run && cnt != TOP) cnt <= cnt + 1'b1;
         end
         assign hit = (cnt == TOP);
      end
   endgenerate
endmodule

// File: rtl/cws_cmd_tx.sv
module cws_cmd_tx
   import card_wake_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        start,
   input  logic [5:0]  idx,
   input  logic [31:0] arg,
   output logic        line,
   output logic        busy,
   output logic        fin
);
   localparam int CW = $clog2(FRAME_W + 1);
   localparam logic [CW-1:0] LAST = CW'(FRAME_W);

   logic [BODY_W-1:0]  body;
   logic [FRAME_W-1:0] sh;
   logic [CW-1:0]      cnt;

   assign body = {1'b0, 1'b1, idx, arg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         line <= 1'b1;
         fin  <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            sh   <= {body, crc7_of(body), 1'b1};
            cnt  <= '0;
            busy <= 1'b1;
         end else if (busy && tick) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               line <= 1'b1;
               fin  <= 1'b1;
            end else begin
               line <= sh[FRAME_W-1];
               sh   <= {sh[FRAME_W-2:0], 1'b1};
               cnt  <= cnt + 1'b1;
            end
         end
      end
   end

   assert_tx_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/cws_rsp_rx.sv
module cws_rsp_rx
   import card_wake_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        en,
   input  logic        din,
   output logic        act,
   output logic        fin,
   output logic [31:0] payload
);
   localparam int CW = $clog2(FRAME_W + 1);
   localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

   logic [FRAME_W-1:0] sh;
   logic [CW-1:0]      cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
         act <= 1'b0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (!en) begin
            act <= 1'b0;
            cnt <= '0;
         end else if (tick && (act || !din)) begin
            sh  <= {sh[FRAME_W-2:0], din};
            cnt <= cnt + 1'b1;
            act <= (cnt != LAST);
            fin <= (cnt == LAST);
            if (cnt == LAST) cnt <= '0;
         end
      end
   end

   assign payload = sh[39:8];

   assert_rx_frame_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> $past(din) == 1'b0);
endmodule

// File: rtl/card_wake_seq.sv
module card_wake_seq
   import card_wake_pkg::*;
#(
   parameter int MS_TICKS  = 50000,
   parameter int SEC_TICKS = 50000000,
   parameter int INIT_CLKS = 74,
   parameter int GAP_CLKS  = 8,
   parameter int RSP_WAIT  = 64,
   parameter int IDX_OP    = 1,
   parameter int IDX_ID    = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cclk_en,
   input  logic        supply_ok,
   input  logic [31:0] op_range,
   input  logic        cmd_in,
   output logic        cmd_out,
   output logic        done,
   output logic        timeout,
   output logic [31:0] ocr
);
   localparam int ICW = $clog2(INIT_CLKS + 1);
   localparam int GCW = $clog2(GAP_CLKS + 1);
   localparam int WCW = $clog2(RSP_WAIT + 1);
   localparam logic [ICW-1:0] INIT_TOP = ICW'(INIT_CLKS);
   localparam logic [GCW-1:0] GAP_TOP  = GCW'(GAP_CLKS - 1);
   localparam logic [WCW-1:0] WAIT_TOP = WCW'(RSP_WAIT - 1);

   generate
      if (INIT_CLKS < 1 || GAP_CLKS < 1 || RSP_WAIT < 1 || SEC_TICKS < 1)
         $error("card_wake_seq: clock counts and limit must be positive");
      if (IDX_OP < 0 || IDX_OP > 63 || IDX_ID < 0 || IDX_ID > 63)
         $error("card_wake_seq: command index out of 6-bit range");
   endgenerate

   seq_st_t        st;
   logic [ICW-1:0] clk_cnt;
   logic [GCW-1:0] gap_cnt;
   logic [WCW-1:0] wait_cnt;
   logic [31:0]    ocr_q;
   logic           ms_hit, sec_hit, clk_ok, init_ok;
   logic           tx_start, start_op, start_id, tx_line, tx_busy, tx_fin;
   logic           rx_act, rx_fin, no_rsp, polling;
   logic [5:0]     tx_idx;
   logic [31:0]    tx_arg, rx_pay;

   assign clk_ok   = (clk_cnt == INIT_TOP);
   assign init_ok  = ms_hit && clk_ok && supply_ok;
   assign polling  = (st == ST_OP_TX) || (st == ST_OP_WAIT) || (st == ST_OP_GAP);
   assign start_op = ((st == ST_INIT) && init_ok) ||
                     ((st == ST_OP_GAP) && !sec_hit && cclk_en && gap_cnt == GAP_TOP);
   assign start_id = (st == ST_ID_GAP) && cclk_en && gap_cnt == GAP_TOP;
   assign tx_start = start_op || start_id;
   assign tx_idx   = start_id ? 6'(IDX_ID) : 6'(IDX_OP);
   assign tx_arg   = start_id ? 32'd0 : op_range;
   assign no_rsp   = (st == ST_OP_WAIT) && cclk_en && !rx_act && cmd_in &&
                     wait_cnt == WAIT_TOP;

   cws_limit_timer #(.LIMIT(MS_TICKS)) u_ms (
      .clk(clk), .rst_n(rst_n), .clear(1'b0), .run(st == ST_INIT), .hit(ms_hit));

   cws_limit_timer #(.LIMIT(SEC_TICKS)) u_sec (
      .clk(clk), .rst_n(rst_n), .clear(st == ST_INIT), .run(polling), .hit(sec_hit));

   cws_cmd_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(cclk_en), .start(tx_start),
      .idx(tx_idx), .arg(tx_arg), .line(tx_line), .busy(tx_busy), .fin(tx_fin));

   cws_rsp_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(cclk_en), .en(st == ST_OP_WAIT),
      .din(cmd_in), .act(rx_act), .fin(rx_fin), .payload(rx_pay));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_INIT;
         clk_cnt  <= '0;
         gap_cnt  <= '0;
         wait_cnt <= '0;
         ocr_q    <= '0;
      end else begin
         unique case (st)
            ST_INIT: begin
               if (cclk_en && !clk_ok) clk_cnt <= clk_cnt + 1'b1;
               if (init_ok) st <= ST_OP_TX;
            end
            ST_OP_TX: begin
               if (sec_hit)     st <= ST_TOUT;
               else if (tx_fin) begin
                  st       <= ST_OP_WAIT;
                  wait_cnt <= '0;
               end
            end
            ST_OP_WAIT: begin
               if (sec_hit) st <= ST_TOUT;
               else if (rx_fin) begin
                  ocr_q   <= rx_pay;
                  gap_cnt <= '0;
                  st      <= rx_pay[31] ? ST_ID_GAP : ST_OP_GAP;
               end else if (no_rsp) begin
                  gap_cnt <= '0;
                  st      <= ST_OP_GAP;
               end else if (cclk_en && !rx_act) begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            ST_OP_GAP: begin
               if (sec_hit) st <= ST_TOUT;
               else if (cclk_en) begin
                  if (gap_cnt == GAP_TOP) st <= ST_OP_TX;
                  else                    gap_cnt <= gap_cnt + 1'b1;
               end
            end
            ST_ID_GAP: begin
               if (cclk_en) begin
                  if (gap_cnt == GAP_TOP) st <= ST_ID_TX;
                  else                    gap_cnt <= gap_cnt + 1'b1;
               end
            end
            ST_ID_TX: if (tx_fin) st <= ST_DONE;
            ST_DONE:  st <= ST_DONE;
            ST_TOUT:  st <= ST_TOUT;
            default:  st <= ST_INIT;
         endcase
      end
   end

   assign cmd_out = ((st == ST_OP_TX) || (st == ST_ID_TX)) ? tx_line : 1'b1;
   assign done    = (st == ST_DONE);
   assign timeout = (st == ST_TOUT);
   assign ocr     = ocr_q;

   assert_tx_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> (st inside {ST_OP_TX, ST_ID_TX, ST_TOUT}));

   assert_init_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OP_TX && $past(st) == ST_INIT) |->
         ($past(supply_ok) && $past(ms_hit) && $past(clk_ok)));

   assert_ocr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE) |=> ($stable(ocr_q) && done));

   assert_timeout_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> $past(sec_hit));

   assert_timeout_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> (timeout && cmd_out && !done));

   assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OP_WAIT) |-> (wait_cnt <= WAIT_TOP));
endmodule

// File: tb/tb_card_wake_seq.sv
module tb_card_wake_seq;
   localparam int CLK_PERIOD = 10;
   localparam int MS_T  = 400;
   localparam int SEC_T = 20000;
   localparam int ICLK  = 74;
   localparam int GAP   = 8;
   localparam int RWAIT = 64;
   localparam int CASE_LIMIT = 60000;
   localparam logic [31:0] OCR_BUSY  = 32'h00FF8000;
   localparam logic [31:0] OCR_READY = 32'h80FF8000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cclk_en = 1'b0;
   logic supply_ok = 1'b0;
   logic [31:0] op_range = '0;
   logic cmd_in = 1'b1;
   logic cmd_out, done, timeout;
   logic [31:0] ocr;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   card_wake_seq #(.MS_TICKS(MS_T), .SEC_TICKS(SEC_T), .INIT_CLKS(ICLK),
                   .GAP_CLKS(GAP), .RSP_WAIT(RWAIT)) dut (
      .clk(clk), .rst_n(rst_n), .cclk_en(cclk_en), .supply_ok(supply_ok),
      .op_range(op_range), .cmd_in(cmd_in), .cmd_out(cmd_out), .done(done),
      .timeout(timeout), .ocr(ocr));

   function automatic logic [6:0] ref_crc(input logic [39:0] body);
      logic [46:0] m;
      m = {body, 7'b0};
      for (int i = 46; i >= 7; i--)
         if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
      return m[6:0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   // mode: 0 listen, 1 capture, 2 reply delay, 3 reply send
   task automatic run_case(input int div, input int sup_dly, input int n_silent,
                           input int n_busy, input bit exp_to, input logic [31:0] rng);
      int t = 0, dcnt = 0, cc = 0, hi_clks = 0, t74 = -1;
      int first_t = -1, mode = 0, bits = 0, dly = 0, k = 0;
      int polls = 0, rsp_end = -1, post = 0;
      bit last_ready = 0, last_busy_rsp = 0, cmd2_seen = 0, done_seen = 0, to_seen = 0;
      bit after_cmd2 = 0;
      logic [47:0] cap = '0, rsp = '0;
      int lower;

      rst_n = 1'b0; cmd_in = 1'b1; supply_ok = 1'b0; cclk_en = 1'b0; op_range = rng;
      repeat (3) @(negedge clk);
      check(cmd_out == 1'b1, "R10", "cmd_out in reset", cmd_out, 1);
      check(!done && !timeout, "R10", "done/timeout in reset", {done, timeout}, 0);
      check(ocr == 32'd0, "R10", "ocr in reset", ocr, 0);
      rst_n = 1'b1;

      while (1) begin
         @(negedge clk);
         t++;
         if (t > CASE_LIMIT) begin
            check(0, "WATCHDOG", "case did not finish", t, CASE_LIMIT);
            break;
         end
         if (timeout && !to_seen) begin
            to_seen = 1;
            mode = 0;
            check(exp_to, "R7", "unexpected timeout", 1, 0);
            if (first_t >= 0)
               check((t - first_t) >= SEC_T - div && (t - first_t) <= SEC_T + 1,
                     "R7", "timeout delay from first start", t - first_t, SEC_T);
         end
         if (done && !done_seen) begin
            done_seen = 1;
            check(cmd2_seen, "R6", "done before identify command", 0, 1);
            check(ocr == OCR_READY, "R6", "ocr at done", ocr, OCR_READY);
         end
         check(!(done && timeout), "R7", "done and timeout together", 1, 0);
         if (to_seen)
            if (!cmd_out) check(0, "R7", "line active after timeout", 0, 1);

         if (cclk_en) begin
            cc++;
            if (cc == ICLK) t74 = t;
            case (mode)
               0: begin
                  if (!cmd_out && !to_seen) begin
                     if (first_t < 0) begin
                        first_t = t;
                        lower = MS_T;
                        if (t74 > lower) lower = t74;
                        if (sup_dly > lower) lower = sup_dly;
                        check(t >= lower && t <= lower + 2*div + 4, "R2",
                              "first start bit time", t, lower);
                        check(hi_clks >= ICLK, "R1", "idle card clocks before first command",
                              hi_clks, ICLK);
                     end
                     if (rsp_end >= 0)
                        check(cc - rsp_end >= GAP + 1, "R8", "turnaround gap", cc - rsp_end, GAP + 1);
                     if (after_cmd2) check(0, "R6", "command after identify", 1, 0);
                     if (last_busy_rsp)
                        check(ocr == OCR_BUSY, "R5", "ocr after busy reply", ocr, OCR_BUSY);
                     rsp_end = -1;
                     last_busy_rsp = 0;
                     cap = {47'b0, cmd_out};
                     bits = 1;
                     mode = 1;
                  end else if (first_t < 0 && cmd_out) begin
                     hi_clks++;
                  end
               end
               1: begin
                  cap = {cap[46:0], cmd_out};
                  bits++;
                  if (bits == 48) begin
                     check(cap[47] == 1'b0 && cap[46] == 1'b1 && cap[0] == 1'b1, "R3",
                           "frame fixed bits", {cap[47], cap[46], cap[0]}, 3'b011);
                     check(cap[7:1] == ref_crc(cap[47:8]), "R3", "frame CRC7",
                           cap[7:1], ref_crc(cap[47:8]));
                     mode = 0;
                     if (last_ready) begin
                        check(cap[45:40] == 6'd2 && cap[39:8] == 32'd0, "R6",
                              "identify command index/arg", cap[45:40], 2);
                        cmd2_seen = 1;
                        after_cmd2 = 1;
                     end else begin
                        check(cap[45:40] == 6'd1, polls == 0 ? "R4" : "R5",
                              "operating-condition index", cap[45:40], 1);
                        check(cap[39:8] == rng, "R4", "argument equals range", cap[39:8], rng);
                        if (polls < n_silent) begin
                           mode = 0;
                        end else begin
                           if (exp_to || polls < n_silent + n_busy) begin
                              rsp = {2'b00, 6'h3F, OCR_BUSY, 7'h7F, 1'b1};
                              last_busy_rsp = 1;
                           end else begin
                              rsp = {2'b00, 6'h3F, OCR_READY, 7'h7F, 1'b1};
                              last_ready = 1;
                           end
                           dly = 2;
                           mode = 2;
                        end
                        polls++;
                     end
                  end
               end
               2: begin
                  if (dly > 1) dly--;
                  else begin
                     cmd_in = rsp[47];
                     k = 1;
                     mode = 3;
                  end
               end
               default: begin
                  if (k == 48) begin
                     cmd_in = 1'b1;
                     mode = 0;
                  end else begin
                     cmd_in = rsp[47 - k];
                     if (k == 47) rsp_end = cc;
                     k++;
                  end
               end
            endcase
         end

         if (done_seen || to_seen) post++;
         if (post > 150 * div) break;

         supply_ok = (t >= sup_dly);
         dcnt = (dcnt == div - 1) ? 0 : dcnt + 1;
         cclk_en = (dcnt == div - 1);
      end

      if (exp_to) begin
         check(to_seen && !done, "R7", "timeout reached", to_seen, 1);
      end else begin
         check(done && !timeout, "R6", "done reached", done, 1);
         check(polls == n_silent + n_busy + 1, n_silent > 0 ? "R9" : "R5",
               "number of operating-condition commands", polls, n_silent + n_busy + 1);
      end
      cclk_en = 1'b0;
   endtask

   initial begin
      run_case(2, 50,   0, 3, 0, 32'h00FF8000);   // time-limited warm-up
      run_case(8, 10,   2, 1, 0, 32'h00300000);   // clock-count-limited, silent polls R9
      run_case(4, 900,  1, 0, 0, 32'h00FF0080);   // supply-limited
      run_case(2, 0,    0, 0, 0, 32'h40FF8000);   // ready at once
      run_case(4, 0,    0, 0, 1, 32'h00FF8000);   // busy for ever -> R7
      run_case(3, 0, 1000, 0, 1, 32'h00018000);   // never answers -> R7, R9
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule